// File: doc/BRIEF.md
# Descriptor-Chained DMA Sequencer

This block is the control sequencer of a DMA engine that moves data between a local bus and a remote system bus. Software sets it up through a small register port. In direct mode, software loads a local address, a remote address, a byte count and a control word, then sets the enable bit. The sequencer then hands chunks to an external data mover until the count is used up.

In chaining mode, the sequencer follows a singly linked list of five-word command packets held in local memory. It fetches each packet through a simple read master and executes it. It then either follows the next pointer or stops. The sequencer never touches the data itself. It drives a request/done/error handshake toward the mover and tracks the counters. It also raises a one-cycle interrupt pulse and keeps a 4-bit interrupt tally and three sticky status flags.

Register map (`regAddr`):
- 0: control. Bit 0 is enable, bit 1 selects chaining mode, bit 2 is halt-at-end.
- 1: control word.
- 2: local address.
- 3: remote address.
- 4: byte count.
- 5: table address.
- 6: status. Bit 0 is done, bit 1 is remote error, bit 2 is fetch error, bits 7:4 are the interrupt tally.
- 7: reads 0.

Control word fields:
- Bits 7:0 are transfer attributes, passed through to the mover.
- Bit 8 is narrow, which gives 2-byte chunks instead of 4-byte chunks.
- Bit 9 is direction.
- Bit 10 is local-increment.
- Bit 11 is remote-increment.
- Bit 15 is packet-interrupt.

Top module: `dmaseq_top`

## Requirements
- R1: After reset, every register reads 0, and `busy`, `irq`, `memReq` and `moverReq` are low.
- R2: In direct mode (control bit 1 = 0), the sequencer runs chunks of min(count, 4) bytes, or min(count, 2) bytes when control-word bit 8 is set. Each completed chunk lowers the byte count by its size. It advances the local address only if bit 10 is set, and the remote address only if bit 11 is set. When the count reaches 0, the sequencer stops with done set and exactly one `irq` pulse. A zero count at enable stops at once with done and one pulse.
- R3: In chaining mode (control bit 1 = 1), each packet is fetched at table address +0, +4, +8, +12 and +16, in that order. The five words are: control word, local address, remote address, byte count and next pointer. The fetched control word overwrites register 1, and register 5 holds the address of the packet being run.
- R4: A packet whose next pointer has bit 0 or bit 1 set is the last one, and finishing it stops the sequencer with done. Otherwise the next pointer is loaded into register 5 and fetching resumes there.
- R5: Finishing a chained packet with control-word bit 15 set raises `irq`. Any final stop raises `irq`. A packet end that is both produces a single pulse, and `busy` never falls without an `irq` pulse in the same cycle.
- R6: With halt-at-end (control bit 2) set in chaining mode, the sequencer stops with done after the current packet. Register 5 still holds that packet's address.
- R7: An error on a descriptor fetch stops the sequencer at once, sets the fetch-error flag and raises `irq`. The mover is never requested for that packet.
- R8: A mover error stops the sequencer at once, sets the remote-error flag and raises `irq`. The byte count keeps only the completed chunks subtracted.
- R9: The interrupt tally counts every `irq` pulse, wraps from 15 to 0, and is cleared by enable.
- R10: The enable bit always reads 0. The status flags are cleared by enable, and at most one of them is set at a time.
- R11: `busy` is high from the enabling write until the final stop. Register writes while `busy` is high are ignored.
- R12: The mover and memory requests are never active together, and neither is active while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| memReq | output | 1 | Descriptor read request, held until answered |
| memAddr | output | 32 | Descriptor word address |
| memAck | input | 1 | Descriptor read completed, `memData` valid |
| memErr | input | 1 | Descriptor read failed |
| memData | input | 32 | Descriptor read data |
| moverReq | output | 1 | Chunk request to the data mover, held until answered |
| moverLocAddr | output | 32 | Local address of the chunk |
| moverRemAddr | output | 32 | Remote address of the chunk |
| moverLen | output | 3 | Chunk size in bytes |
| moverCtrl | output | 16 | Current control word |
| moverDone | input | 1 | Chunk completed |
| moverErr | input | 1 | Chunk failed on the remote bus |
| busy | output | 1 | Sequencer active |
| irq | output | 1 | One-cycle interrupt pulse |
| irqCount | output | 4 | Interrupt tally |
| doneFlag | output | 1 | Finished normally or halted |
| remErrFlag | output | 1 | Stopped on a mover error |
| fetchErrFlag | output | 1 | Stopped on a descriptor fetch error |

## Verification
The assertions assume the memory and mover sides answer only while the matching request is high. Each request gets a single one-cycle `memAck`/`memErr` or `moverDone`/`moverErr` pulse, and the two pulses of a pair never come together. The bench models both responders so that they only ever answer a request they see at the falling edge. Each answer is cleared on the next falling edge, so every reply is a clean single-cycle pulse. Errors are injected only by matching a chosen descriptor address or chunk index. Software writes that land while `busy` is high are deliberate, and they probe that such writes are ignored.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_END
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       clrStatus;
    logic       loadWord;
    logic [2:0] wordIdx;
    logic       xferStep;
    logic       setDone;
    logic       setRemErr;
    logic       setFetchErr;
    logic       raiseIrq;
    logic       loadNext;
  } dpStrobe_t;

  localparam int PKT_WORDS = 5;
  localparam int CW_NARROW = 8;
  localparam int CW_LOCINC = 10;
  localparam int CW_REMINC = 11;
  localparam int CW_PKTIRQ = 15;
endpackage

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
  import dmaseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      startChain,
  input  logic      chainMode,
  input  logic      haltAtEnd,
  input  logic      countZero,
  input  logic      lastChunk,
  input  logic      listEnd,
  input  logic      pktIrqEn,
  input  logic      memAck,
  input  logic      memErr,
  input  logic      moverDone,
  input  logic      moverErr,
  output logic      busy,
  output logic      memReq,
  output logic      moverReq,
  output dpStrobe_t strobe
);
  localparam logic [2:0] LAST_IDX = 3'(PKT_WORDS - 1);

  seqState_t state, nState;
  logic [2:0] idx, nIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= nState;
      idx   <= nIdx;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.wordIdx = idx;
    nState         = state;
    nIdx           = idx;
    unique case (state)
      ST_IDLE: if (startPulse) begin
        strobe.clrStatus = 1'b1;
        nIdx = '0;
        if (startChain)     nState = ST_FETCH;
        else if (countZero) nState = ST_END;
        else                nState = ST_XFER;
      end
      ST_FETCH: begin
        if (memErr) begin
          strobe.setFetchErr = 1'b1;
          strobe.raiseIrq    = 1'b1;
          nState = ST_IDLE;
        end else if (memAck) begin
          strobe.loadWord = 1'b1;
          if (idx == LAST_IDX) nState = countZero ? ST_END : ST_XFER;
          else                 nIdx = idx + 3'd1;
        end
      end
      ST_XFER: begin
        if (moverErr) begin
          strobe.setRemErr = 1'b1;
          strobe.raiseIrq  = 1'b1;
          nState = ST_IDLE;
        end else if (moverDone) begin
          strobe.xferStep = 1'b1;
          if (lastChunk) nState = ST_END;
        end
      end
      ST_END: begin
        if (!chainMode || listEnd || haltAtEnd) begin
          strobe.setDone  = 1'b1;
          strobe.raiseIrq = 1'b1;
          nState = ST_IDLE;
        end else begin
          strobe.raiseIrq = pktIrqEn;
          strobe.loadNext = 1'b1;
          nIdx = '0;
          nState = ST_FETCH;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign memReq   = (state == ST_FETCH);
  assign moverReq = (state == ST_XFER);
endmodule

// File: rtl/dmaseq_dp.sv
module dmaseq_dp
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int CHUNK_BYTES  = 4,
  parameter int NARROW_BYTES = 2,
  parameter int ICNT_W       = 4,
  localparam int LEN_W       = $clog2(CHUNK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWr,
  input  logic [2:0]        regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] moverLocAddr,
  output logic [ADDR_W-1:0] moverRemAddr,
  output logic [LEN_W-1:0]  moverLen,
  output logic [15:0]       moverCtrl,
  output logic              irq,
  output logic [ICNT_W-1:0] irqCount,
  output logic              doneFlag,
  output logic              remErrFlag,
  output logic              fetchErrFlag,
  output logic              chainMode,
  output logic              haltAtEnd,
  output logic              countZero,
  output logic              lastChunk,
  output logic              listEnd,
  output logic              pktIrqEn
);
  logic [15:0]       ctrlWord;
  logic [ADDR_W-1:0] locAddr, remAddr, byteCount, tableAddr, nextPtr;
  logic [LEN_W-1:0]  chunk;
  logic [ADDR_W-1:0] step;

  assign chunk     = ctrlWord[CW_NARROW] ? LEN_W'(NARROW_BYTES) : LEN_W'(CHUNK_BYTES);
  assign lastChunk = byteCount <= ADDR_W'(chunk);
  assign moverLen  = lastChunk ? byteCount[LEN_W-1:0] : chunk;
  assign step      = ADDR_W'(moverLen);
  assign countZero = (byteCount == '0);
  assign listEnd   = |nextPtr[1:0];
  assign pktIrqEn  = ctrlWord[CW_PKTIRQ];
  assign memAddr   = tableAddr + ADDR_W'({strobe.wordIdx, 2'b00});

  assign moverLocAddr = locAddr;
  assign moverRemAddr = remAddr;
  assign moverCtrl    = ctrlWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord <= '0;  locAddr <= '0;  remAddr <= '0;
      byteCount <= '0; tableAddr <= '0; nextPtr <= '0;
      chainMode <= 1'b0; haltAtEnd <= 1'b0;
      doneFlag <= 1'b0; remErrFlag <= 1'b0; fetchErrFlag <= 1'b0;
      irqCount <= '0; irq <= 1'b0;
    end else begin
      irq <= strobe.raiseIrq;
      if (swWr) begin
        unique case (regAddr)
          3'd0: begin chainMode <= regWrData[1]; haltAtEnd <= regWrData[2]; end
          3'd1: ctrlWord  <= regWrData[15:0];
          3'd2: locAddr   <= regWrData;
          3'd3: remAddr   <= regWrData;
          3'd4: byteCount <= regWrData;
          3'd5: tableAddr <= regWrData;
          default: ;
        endcase
      end
      if (strobe.loadWord) begin
        unique case (strobe.wordIdx)
          3'd0: ctrlWord  <= memData[15:0];
          3'd1: locAddr   <= memData;
          3'd2: remAddr   <= memData;
          3'd3: byteCount <= memData;
          default: nextPtr <= memData;
        endcase
      end
      if (strobe.xferStep) begin
        byteCount <= byteCount - step;
        if (ctrlWord[CW_LOCINC]) locAddr <= locAddr + step;
        if (ctrlWord[CW_REMINC]) remAddr <= remAddr + step;
      end
      if (strobe.loadNext) tableAddr <= nextPtr;
      if (strobe.clrStatus) begin
        doneFlag <= 1'b0; remErrFlag <= 1'b0; fetchErrFlag <= 1'b0;
        irqCount <= '0;
      end else if (strobe.raiseIrq) begin
        irqCount <= irqCount + 1'b1;
      end
      if (strobe.setDone)     doneFlag     <= 1'b1;
      if (strobe.setRemErr)   remErrFlag   <= 1'b1;
      if (strobe.setFetchErr) fetchErrFlag <= 1'b1;
    end
  end

  always_comb begin
    unique case (regAddr)
      3'd0: regRdData = ADDR_W'({haltAtEnd, chainMode, 1'b0});
      3'd1: regRdData = ADDR_W'(ctrlWord);
      3'd2: regRdData = locAddr;
      3'd3: regRdData = remAddr;
      3'd4: regRdData = byteCount;
      3'd5: regRdData = tableAddr;
      3'd6: regRdData = ADDR_W'({irqCount, 1'b0, fetchErrFlag, remErrFlag, doneFlag});
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int CHUNK_BYTES  = 4,
  parameter int NARROW_BYTES = 2,
  parameter int ICNT_W       = 4,
  localparam int LEN_W       = $clog2(CHUNK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic              memErr,
  input  logic [ADDR_W-1:0] memData,
  output logic              moverReq,
  output logic [ADDR_W-1:0] moverLocAddr,
  output logic [ADDR_W-1:0] moverRemAddr,
  output logic [LEN_W-1:0]  moverLen,
  output logic [15:0]       moverCtrl,
  input  logic              moverDone,
  input  logic              moverErr,
  output logic              busy,
  output logic              irq,
  output logic [ICNT_W-1:0] irqCount,
  output logic              doneFlag,
  output logic              remErrFlag,
  output logic              fetchErrFlag
);
  dpStrobe_t strobe;
  logic chainMode, haltAtEnd, countZero, lastChunk, listEnd, pktIrqEn;
  logic swWr, startPulse;

  assign swWr       = regWrEn && !busy;
  assign startPulse = swWr && (regAddr == 3'd0) && regWrData[0];

  dmaseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startChain(regWrData[1]),
    .chainMode(chainMode), .haltAtEnd(haltAtEnd), .countZero(countZero),
    .lastChunk(lastChunk), .listEnd(listEnd), .pktIrqEn(pktIrqEn),
    .memAck(memAck), .memErr(memErr), .moverDone(moverDone), .moverErr(moverErr),
    .busy(busy), .memReq(memReq), .moverReq(moverReq), .strobe(strobe)
  );

  dmaseq_dp #(
    .ADDR_W(ADDR_W), .CHUNK_BYTES(CHUNK_BYTES),
    .NARROW_BYTES(NARROW_BYTES), .ICNT_W(ICNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .swWr(swWr), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .strobe(strobe), .memData(memData), .memAddr(memAddr),
    .moverLocAddr(moverLocAddr), .moverRemAddr(moverRemAddr), .moverLen(moverLen),
    .moverCtrl(moverCtrl), .irq(irq), .irqCount(irqCount), .doneFlag(doneFlag),
    .remErrFlag(remErrFlag), .fetchErrFlag(fetchErrFlag), .chainMode(chainMode),
    .haltAtEnd(haltAtEnd), .countZero(countZero), .lastChunk(lastChunk),
    .listEnd(listEnd), .pktIrqEn(pktIrqEn)
  );
endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk #(
  parameter int ICNT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              irq,
  input logic              memReq,
  input logic              moverReq,
  input logic [ICNT_W-1:0] irqCount,
  input logic              doneFlag,
  input logic              remErrFlag,
  input logic              fetchErrFlag
);
  a_r5_stop_irq: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irq);

  a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && moverReq));

  a_r12_req_busy: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || moverReq) |-> busy);

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> irqCount == ICNT_W'($past(irqCount) + 1'b1));

  a_r10_one_flag: assert property (@(posedge clk) disable iff (!rstN)
    $countones({doneFlag, remErrFlag, fetchErrFlag}) <= 1);

  a_r7_fetch_err_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fetchErrFlag) |-> (!busy && irq));

  a_r8_rem_err_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(remErrFlag) |-> (!busy && irq));
endmodule

bind dmaseq_top dmaseq_chk #(.ICNT_W(ICNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .irq(irq), .memReq(memReq),
  .moverReq(moverReq), .irqCount(irqCount), .doneFlag(doneFlag),
  .remErrFlag(remErrFlag), .fetchErrFlag(fetchErrFlag)
);

// File: tb/dmaseq_top_tb.sv
module dmaseq_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq, memAck = 1'b0, memErr = 1'b0;
  logic [31:0] memAddr, memData = '0;
  logic        moverReq, moverDone = 1'b0, moverErr = 1'b0;
  logic [31:0] moverLocAddr, moverRemAddr;
  logic [2:0]  moverLen;
  logic [15:0] moverCtrl;
  logic        busy, irq, doneFlag, remErrFlag, fetchErrFlag;
  logic [3:0]  irqCount;

  always #4 clk = ~clk;

  dmaseq_top u_dut (.*);

  int nChecks = 0, nErr = 0, cycles = 0;
  logic [31:0] mem [128];
  logic [31:0] errAddr = 32'hFFFF_FFFF;
  int errIdx = -1, moverIdx = 0, xfers = 0, irqPulses = 0, nFetch = 0;
  logic [31:0] fetchLog [64];

  // memory responder
  always @(negedge clk) begin
    if (memAck || memErr) begin
      memAck = 1'b0; memErr = 1'b0;
    end else if (memReq) begin
      if (memAddr == errAddr) memErr = 1'b1;
      else begin
        memAck = 1'b1;
        memData = mem[memAddr[8:2]];
        if (nFetch < 64) fetchLog[nFetch] = memAddr;
        nFetch++;
      end
    end
  end

  // mover responder
  always @(negedge clk) begin
    if (moverDone || moverErr) begin
      moverDone = 1'b0; moverErr = 1'b0;
    end else if (moverReq) begin
      if (moverIdx == errIdx) moverErr = 1'b1;
      else begin moverDone = 1'b1; xfers++; end
      moverIdx++;
    end
  end

  always @(negedge clk) if (irq) irqPulses++;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdData;
  endtask

  task automatic clearRun();
    xfers = 0; irqPulses = 0; nFetch = 0; moverIdx = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    do begin @(negedge clk); n++; end while (busy && n < 5000);
    if (busy) chk("R11 timeout", 32'd1, 32'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic putPkt(input int base, input logic [31:0] cw, input logic [31:0] la,
                        input logic [31:0] ra, input logic [31:0] cnt, input logic [31:0] nx);
    mem[base/4]   = cw; mem[base/4+1] = la; mem[base/4+2] = ra;
    mem[base/4+3] = cnt; mem[base/4+4] = nx;
  endtask

  typedef struct packed {
    logic [31:0] loc, rem, cnt;
    logic [15:0] cw;
    logic [7:0]  nx;
    logic [31:0] eLoc, eRem;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h1000, 32'h8000, 32'd10, 16'h0C00, 8'd3, 32'h100A, 32'h800A},
    '{32'h2000, 32'h9000, 32'd7,  16'h0500, 8'd4, 32'h2007, 32'h9000},
    '{32'h3000, 32'hA000, 32'd0,  16'h0C00, 8'd0, 32'h3000, 32'hA000},
    '{32'h4000, 32'hB000, 32'd3,  16'h0000, 8'd1, 32'h4000, 32'hB000},
    '{32'h5000, 32'hC000, 32'd5,  16'h0800, 8'd2, 32'h5000, 32'hC005}
  };

  logic [31:0] r;

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), r); chk("R1 reg", r, 32'd0); end
    chk("R1 outputs", {28'd0, busy, irq, memReq, moverReq}, 32'd0);

    // R2 direct mode vectors
    for (int v = 0; v < 5; v++) begin
      clearRun();
      wr(2, VECS[v].loc); wr(3, VECS[v].rem); wr(4, VECS[v].cnt);
      wr(1, 32'(VECS[v].cw)); wr(0, 32'h1);
      waitIdle();
      chk("R2 chunks", 32'(xfers), 32'(VECS[v].nx));
      rd(2, r); chk("R2 local addr", r, VECS[v].eLoc);
      rd(3, r); chk("R2 remote addr", r, VECS[v].eRem);
      rd(4, r); chk("R2 count", r, 32'd0);
      rd(6, r); chk("R2 status", r, 32'h11);
      chk("R2 irq pulses", 32'(irqPulses), 32'd1);
    end

    // Chain list
    putPkt(32'h000, 32'h8C00, 32'h100, 32'h200, 32'd8, 32'h040);
    putPkt(32'h040, 32'h0C00, 32'h300, 32'h400, 32'd4, 32'h080);
    putPkt(32'h080, 32'h8900, 32'h500, 32'h600, 32'd3, 32'h001);

    // R3 R4 R5 chaining
    clearRun();
    wr(5, 32'h000); wr(0, 32'h3);
    rd(0, r); chk("R10 enable reads 0", r, 32'h2);
    waitIdle();
    for (int k = 0; k < 5; k++) chk("R3 fetch order", fetchLog[k], 32'(4 * k));
    chk("R3 fetch count", 32'(nFetch), 32'd15);
    chk("R4 chunks", 32'(xfers), 32'd5);
    chk("R5 irq pulses", 32'(irqPulses), 32'd2);
    rd(6, r); chk("R9 tally", r, 32'h21);
    rd(5, r); chk("R3 table addr", r, 32'h080);
    rd(1, r); chk("R3 ctrl word", r, 32'h8900);
    rd(3, r); chk("R4 remote addr", r, 32'h603);

    // R6 halt at end
    clearRun();
    wr(5, 32'h000); wr(0, 32'h7);
    waitIdle();
    chk("R6 chunks", 32'(xfers), 32'd2);
    chk("R6 irq pulses", 32'(irqPulses), 32'd1);
    rd(5, r); chk("R6 table addr", r, 32'h000);
    rd(6, r); chk("R6 status", r, 32'h11);

    // R7 fetch error on packet 2 count word
    clearRun();
    errAddr = 32'h04C;
    wr(5, 32'h000); wr(0, 32'h3);
    waitIdle();
    errAddr = 32'hFFFF_FFFF;
    chk("R7 chunks", 32'(xfers), 32'd2);
    chk("R7 irq pulses", 32'(irqPulses), 32'd2);
    rd(6, r); chk("R7 status", r, 32'h24);
    rd(5, r); chk("R7 table addr", r, 32'h040);

    // R8 mover error on second chunk
    clearRun();
    errIdx = 1;
    wr(2, 32'h1000); wr(3, 32'h2000); wr(4, 32'd10); wr(1, 32'h0C00); wr(0, 32'h1);
    waitIdle();
    errIdx = -1;
    chk("R8 chunks", 32'(xfers), 32'd1);
    rd(4, r); chk("R8 count", r, 32'd6);
    rd(6, r); chk("R8 status", r, 32'h12);
    chk("R8 irq pulses", 32'(irqPulses), 32'd1);

    // R11 writes ignored while busy
    clearRun();
    wr(2, 32'h7000); wr(3, 32'h6000); wr(4, 32'd12); wr(1, 32'h0D00); wr(0, 32'h1);
    chk("R11 busy", {31'd0, busy}, 32'd1);
    wr(4, 32'h55); wr(2, 32'hDEAD);
    waitIdle();
    chk("R11 chunks", 32'(xfers), 32'd6);
    rd(4, r); chk("R11 count", r, 32'd0);
    rd(2, r); chk("R11 local addr", r, 32'h700C);
    chk("R11 idle", {31'd0, busy}, 32'd0);

    // R9 tally wrap: 17 zero-count packets with packet interrupt
    for (int p = 0; p < 17; p++)
      putPkt(p * 20, 32'h8000, 32'h0, 32'h0, 32'd0, (p == 16) ? 32'h1 : 32'((p + 1) * 20));
    clearRun();
    wr(5, 32'h000); wr(0, 32'h3);
    waitIdle();
    chk("R9 irq pulses", 32'(irqPulses), 32'd17);
    rd(6, r); chk("R9 wrap", r, 32'h11);
    chk("R9 chunks", 32'(xfers), 32'd0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule